// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written by a host into an asynchronous serial character stream. The host writes a byte into a single-entry holding register. Whenever the shift stage is idle and a byte is pending, the byte moves into the shift stage and goes out as a frame: a low start bit, then 5 to 8 data bits with bit 0 first, then an optional parity bit, then the stop interval. The holding register frees up as soon as its byte has moved, so the host can supply the next byte while the current one is still on the line.

One 7-bit control word sets the frame shape: word length, stop length, whether parity is on, even or odd sense, forced ("stick") parity and a break override. Bit timing comes from an oversampling enable that pulses at 16 times the bit rate; every bit lasts 16 pulses, and a half bit lasts 8. Two flags report state: one when the holding register is free, and one when nothing is left to send at all.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset and whenever nothing is being sent, `txd` is 1 unless break is on. In the clock cycle right after a pending byte moves into the idle shift stage, `txd` goes to 0 for a start bit of 16 `tick16` pulses.
- R2: Data bits follow the start bit with bit 0 first, each lasting 16 pulses. Their count comes from `line_ctrl[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of the byte above that count are not sent.
- R3: With `line_ctrl[3]`=1 a parity bit of 16 pulses follows the data. With `line_ctrl[4]`=1 it makes the count of ones in the data bits plus parity even. With `line_ctrl[4]`=0 that count is odd. With `line_ctrl[3]`=0 no parity bit is sent.
- R4: With `line_ctrl[3]`=1 and `line_ctrl[5]`=1 the parity bit is fixed at the inverse of `line_ctrl[4]`, whatever the data.
- R5: With `line_ctrl[2]`=0 the stop interval is one bit of 16 pulses at level 1. With `line_ctrl[2]`=1 it is 24 pulses for 5-bit words and 32 pulses for 6-, 7- and 8-bit words.
- R6: While `line_ctrl[6]`=1, `txd` is 0 in the same cycle, whatever the shift stage is doing. Frame timing carries on underneath, so the frame resumes at its current position when break is cleared.
- R7: `hold_empty` is 1 after reset and is 0 in the cycle after a write. It goes back to 1 in the cycle after its byte moves into the shift stage. A write made while it is 0 replaces the pending byte, and the replaced byte is never sent.
- R8: `tx_empty` is 1 only when `hold_empty` is 1 and no frame is in progress. It returns to 1 in the cycle after the last stop pulse.
- R9: Bits 0 to 5 of `line_ctrl` are sampled when a byte moves into the shift stage. Changing them during a frame has no effect on that frame.
- R10: `txd` changes only in a cycle that follows a `tick16` pulse, a transfer into the shift stage, or a change of the break bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| line_ctrl | input | 7 | Frame control: [1:0] length, [2] stop, [3] parity on, [4] even, [5] stick, [6] break |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register free |
| tx_empty | output | 1 | Holding register and shift stage both idle |

## Verification
On every cycle the assertions check several rules. The idle line sits high. The start bit is low in the cycle after a transfer. A write always clears `hold_empty`. `tx_empty` never shows while a byte is pending. The line changes only after a tick, a transfer or a break edge. The bit order, the word-length masking, the parity sense and stick values, the 24- and 32-pulse stop intervals, the overwrite of a pending byte and the capture of the control word at transfer can only be shown by the bench scenarios. There, the cycle-by-cycle frame model predicts every line level.

// File: rtl/stx_pkg.sv
package stx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_STOPX
   } stx_state_e;

   typedef struct packed {
      logic       brk;
      logic       stick;
      logic       even;
      logic       par_en;
      logic       stop_x;
      logic [1:0] wlen;
   } stx_cfg_t;

endpackage

// File: rtl/stx_hold.sv
module stx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              xfer,
   output logic [DATA_W-1:0] hold_q,
   output logic              hold_empty
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q     <= '0;
         hold_empty <= 1'b1;
      end else begin
         if (wr_en) begin
            hold_q     <= wr_data;
            hold_empty <= 1'b0;
         end else if (xfer) begin
            hold_empty <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/stx_parity.sv
module stx_parity #(
   parameter int DATA_W = 8,
   parameter int IMPL   = 0,
   localparam int BW    = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [BW-1:0]     last_idx,
   input  logic              even,
   input  logic              stick,
   output logic              par
);

   logic [DATA_W-1:0] masked;
   logic              ones_odd;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign masked[i] = data[i] & (BW'(i) <= last_idx);
   end

   if (IMPL == 0) begin : g_reduce
      assign ones_odd = ^masked;
   end else begin : g_chain
      logic [DATA_W:0] chain;
      assign chain[0] = 1'b0;
      for (genvar j = 0; j < DATA_W; j++) begin : g_link
         assign chain[j+1] = chain[j] ^ masked[j];
      end
      assign ones_odd = chain[DATA_W];
   end

   always_comb begin
      if (stick)     par = ~even;
      else if (even) par = ones_odd;
      else           par = ~ones_odd;
   end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   localparam int BW    = $clog2(DATA_W),
   localparam int CW    = $clog2(OVS),
   localparam int HALF  = OVS / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic [BW-1:0]     load_last,
   input  logic              load_pen,
   input  logic              load_sx,
   input  logic              load_half,
   input  logic              load_par,
   output logic              busy,
   output logic              line
);

   stx_state_e        st;
   logic [CW-1:0]     tcnt;
   logic [BW-1:0]     bcnt;
   logic [BW-1:0]     last_q;
   logic [DATA_W-1:0] sh_q;
   logic              pen_q;
   logic              sx_q;
   logic              half_q;
   logic              par_q;
   logic [CW-1:0]     seg_last;
   logic              seg_end;

   assign seg_last = (st == ST_STOPX && half_q) ? CW'(HALF - 1) : CW'(OVS - 1);
   assign seg_end  = tick && (tcnt == seg_last);
   assign busy     = (st != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         tcnt   <= '0;
         bcnt   <= '0;
         last_q <= '0;
         sh_q   <= '0;
         pen_q  <= 1'b0;
         sx_q   <= 1'b0;
         half_q <= 1'b0;
         par_q  <= 1'b0;
      end else if (load) begin
         st     <= ST_START;
         tcnt   <= '0;
         bcnt   <= '0;
         last_q <= load_last;
         sh_q   <= load_data;
         pen_q  <= load_pen;
         sx_q   <= load_sx;
         half_q <= load_half;
         par_q  <= load_par;
      end else if (tick && st != ST_IDLE) begin
         if (!seg_end) begin
            tcnt <= tcnt + 1'b1;
         end else begin
            tcnt <= '0;
            case (st)
               ST_START: begin
                  st   <= ST_DATA;
                  bcnt <= '0;
               end
               ST_DATA: begin
                  sh_q <= sh_q >> 1;
                  if (bcnt == last_q) st <= pen_q ? ST_PAR : ST_STOP;
                  else                bcnt <= bcnt + 1'b1;
               end
               ST_PAR:   st <= ST_STOP;
               ST_STOP:  st <= sx_q ? ST_STOPX : ST_IDLE;
               default:  st <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (st)
         ST_START: line = 1'b0;
         ST_DATA:  line = sh_q[0];
         ST_PAR:   line = par_q;
         default:  line = 1'b1;
      endcase
   end

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
   import stx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVS        = 16,
   parameter int PARITY_IMPL = 0,
   localparam int BW        = $clog2(DATA_W),
   localparam int MIN_BITS  = DATA_W - 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [6:0]        line_ctrl,
   output logic              txd,
   output logic              hold_empty,
   output logic              tx_empty
);

   if (DATA_W != 8) begin : g_bad_width
      $error("serial_tx_engine: DATA_W must be 8 for the 2-bit length code");
   end
   if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("serial_tx_engine: OVS must be even and at least 2");
   end
   if (PARITY_IMPL != 0 && PARITY_IMPL != 1) begin : g_bad_impl
      $error("serial_tx_engine: PARITY_IMPL must be 0 or 1");
   end

   stx_cfg_t          cfg;
   logic [DATA_W-1:0] hold_q;
   logic [BW-1:0]     last_idx;
   logic              par_bit;
   logic              busy;
   logic              line;
   logic              xfer;
   logic              brk_on;

   assign cfg      = stx_cfg_t'(line_ctrl);
   assign brk_on   = cfg.brk;
   assign last_idx = BW'(MIN_BITS - 1) + BW'(cfg.wlen);
   assign xfer     = !hold_empty && !busy;

   stx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .xfer       (xfer),
      .hold_q     (hold_q),
      .hold_empty (hold_empty)
   );

   stx_parity #(.DATA_W(DATA_W), .IMPL(PARITY_IMPL)) u_par (
      .data     (hold_q),
      .last_idx (last_idx),
      .even     (cfg.even),
      .stick    (cfg.stick),
      .par      (par_bit)
   );

   stx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick16),
      .load      (xfer),
      .load_data (hold_q),
      .load_last (last_idx),
      .load_pen  (cfg.par_en),
      .load_sx   (cfg.stop_x),
      .load_half (cfg.stop_x && cfg.wlen == 2'b00),
      .load_par  (par_bit),
      .busy      (busy),
      .line      (line)
   );

   assign txd      = brk_on ? 1'b0 : line;
   assign tx_empty = hold_empty && !busy;

endmodule

// File: rtl/stx_chk.sv
module stx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick16,
   input logic xfer,
   input logic wr_en,
   input logic brk,
   input logic txd,
   input logic hold_empty,
   input logic tx_empty
);

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && !brk) |-> txd); // R1

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty) |-> !txd); // R1

   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !hold_empty); // R7

   AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> hold_empty); // R8

   AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!tick16 && !xfer) && $stable(brk)) |-> $stable(txd)); // R10

endmodule

bind serial_tx_engine stx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick16     (tick16),
   .xfer       (xfer),
   .wr_en      (wr_en),
   .brk        (brk_on),
   .txd        (txd),
   .hold_empty (hold_empty),
   .tx_empty   (tx_empty)
);

// File: tb/sim_serial_tx_engine.sv
`timescale 1ns/1ps
module sim_serial_tx_engine;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [6:0] line_ctrl = 7'b0000011;
   logic       txd, hold_empty, tx_empty;

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R1";
   int    tick_mode = 0;
   bit    done = 0;

   always #5 clk = ~clk;

   serial_tx_engine u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
      .wr_data(wr_data), .line_ctrl(line_ctrl), .txd(txd),
      .hold_empty(hold_empty), .tx_empty(tx_empty)
   );

   // behavioural frame model: list of (level, pulse count) segments
   int         q_val[$];
   int         q_len[$];
   int         m_rem;
   bit         m_he;
   logic [7:0] m_hold;

   function automatic void build_frame(logic [7:0] d, logic [6:0] c);
      int nb = 5 + int'(c[1:0]);
      int ones = 0;
      int p;
      q_val.push_back(0); q_len.push_back(16);
      for (int i = 0; i < nb; i++) begin
         q_val.push_back(int'(d[i])); q_len.push_back(16);
         ones += int'(d[i]);
      end
      if (c[3]) begin
         if (c[5])      p = c[4] ? 0 : 1;
         else if (c[4]) p = ones % 2;
         else           p = 1 - (ones % 2);
         q_val.push_back(p); q_len.push_back(16);
      end
      q_val.push_back(1); q_len.push_back(16);
      if (c[2]) begin
         q_val.push_back(1); q_len.push_back(nb == 5 ? 8 : 16);
      end
      m_rem = q_len[0];
   endfunction

   always @(posedge clk) begin
      bit ld;
      ld = 0;
      if (!rst_n) begin
         q_val.delete(); q_len.delete();
         m_rem = 0; m_he = 1; m_hold = '0;
      end else begin
         if (q_val.size() > 0) begin
            if (tick16) begin
               m_rem--;
               if (m_rem == 0) begin
                  void'(q_val.pop_front());
                  void'(q_len.pop_front());
                  if (q_val.size() > 0) m_rem = q_len[0];
               end
            end
         end else if (!m_he) begin
            build_frame(m_hold, line_ctrl);
            ld = 1;
         end
         if (wr_en) begin
            m_hold = wr_data;
            m_he   = 0;
         end else if (ld) begin
            m_he = 1;
         end
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic e_txd;
         e_txd = line_ctrl[6] ? 1'b0 : (q_val.size() > 0 ? logic'(q_val[0][0]) : 1'b1);
         chk(cur_req, "txd", txd, e_txd);
         chk(cur_req, "hold_empty", hold_empty, m_he);
         chk(cur_req, "tx_empty", tx_empty, m_he && q_val.size() == 0);
      end
   end

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk); #3;
         cyc++;
         tick16 = (tick_mode == 0) ? (cyc % 3 == 0) : 1'($urandom % 2);
      end
   end

   task automatic write_byte(logic [7:0] b);
      @(posedge clk); #3;
      wr_en = 1; wr_data = b;
      @(posedge clk); #3;
      wr_en = 0;
   endtask

   task automatic set_ctrl(logic [6:0] c);
      @(posedge clk); #3;
      line_ctrl = c;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (!(m_he && q_val.size() == 0) && n < 5000) begin
         @(posedge clk); n++;
      end
      repeat (4) @(posedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #1_500_000;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk); #3;
      rst_n = 1;
      @(negedge clk);
      // reset state: R1 line high, R7 holding free, R8 all empty
      chk("R1", "reset txd", txd, 1'b1);
      chk("R7", "reset hold_empty", hold_empty, 1'b1);
      chk("R8", "reset tx_empty", tx_empty, 1'b1);

      cur_req = "R2"; set_ctrl(7'b0000011); write_byte(8'hA5); wait_idle();
      cur_req = "R2"; set_ctrl(7'b0000000); write_byte(8'hFF); wait_idle();
      cur_req = "R3"; set_ctrl(7'b0011001); write_byte(8'h2D); wait_idle();
      cur_req = "R3"; set_ctrl(7'b0001011); write_byte(8'h37); wait_idle();
      cur_req = "R4"; set_ctrl(7'b0101010); write_byte(8'h00); wait_idle();
      cur_req = "R4"; set_ctrl(7'b0111010); write_byte(8'h7F); wait_idle();
      cur_req = "R5"; set_ctrl(7'b0001100); write_byte(8'h15); wait_idle();
      cur_req = "R5"; set_ctrl(7'b0000111); write_byte(8'hC3); wait_idle();

      // double buffering and overwrite of pending byte
      cur_req = "R7"; set_ctrl(7'b0000011);
      write_byte(8'h11);
      repeat (20) @(posedge clk);
      write_byte(8'h22);
      repeat (20) @(posedge clk);
      write_byte(8'h33);
      wait_idle();
      cur_req = "R8"; write_byte(8'h81); write_byte(8'h42); wait_idle();

      // break over a running frame
      cur_req = "R6"; write_byte(8'h5A);
      repeat (60) @(posedge clk);
      set_ctrl(7'b1000011);
      repeat (90) @(posedge clk);
      set_ctrl(7'b0000011);
      wait_idle();

      // control change mid-frame
      cur_req = "R9"; set_ctrl(7'b0001011); write_byte(8'h96);
      repeat (50) @(posedge clk);
      set_ctrl(7'b0110100);
      wait_idle();

      // irregular tick pattern
      cur_req = "R10"; tick_mode = 1; set_ctrl(7'b0011110);
      write_byte(8'hE7); write_byte(8'h3C); wait_idle();
      set_ctrl(7'b0000100); write_byte(8'h09); wait_idle();

      finish_run();
   end

endmodule